// File: doc/BRIEF.md
# Shadow Register Update Sequencer

This block sits between a fast register bus and a slow, always-on register domain that holds eight shadowed registers: six persistent registers (indices 0 to 5), the alarm (index 6) and the seconds count (index 7). Each bus write lands in a fast-side pending copy and marks that register stale. The block then hands pending registers, one per transfer, to the slow domain. The slow copies change only through these transfers. Software polls the stale bitmap in a status word and trusts a read-back only once the stale bit for that register is clear.

Transfers leave on a valid/ready stream. `cp_valid` is high whenever any register is stale. `cp_idx` and `cp_data` name the lowest-numbered stale register and its newest pending value. The slow domain raises `cp_ready` in each update slot in which it can take a transfer. A transfer completes on a cycle where both `cp_valid` and `cp_ready` are high. While `cp_ready` is low the offer is held. The write side never back-pressures: `wr_ready` is tied high, and a write is accepted on any cycle in which `wr_valid` is high.

A recopy of everything can be forced in two ways: by pulsing `force_upd`, or by writing persistent register 1 with its force bit set. Either one marks all eight registers stale, and the normal priority order then drains them.

Top module: `shadow_upd_seq`

## Requirements
- R1: After reset `stale_map` is 0, `stat_word` is 0, `cp_valid` is 0 and every slow copy read through `rd_idx`/`rd_data` is 0.
- R2: `wr_ready` is always 1. An accepted write to index `wr_idx` sets `stale_map[wr_idx]` on the next cycle and stores `wr_data` as that register's pending value.
- R3: `stat_word` carries `stale_map[i]` at bit 16+i: seconds (index 7) is bit 23 and persistent 0 is bit 16. All other bits of `stat_word` are 0.
- R4: `cp_valid` is 1 exactly when some stale bit is set. `cp_idx` is then the lowest stale index, so the order is persistent 0 to 5, then alarm (6), then seconds (7). `cp_data` is that register's pending value.
- R5: A handshake (`cp_valid` and `cp_ready` both 1) writes `cp_data` into slow copy `cp_idx`, visible on `rd_data` the next cycle. It also clears that stale bit, unless R7 or R8 applies in the same cycle.
- R6: Rewriting a register that is still stale keeps it stale. The newest value is the one later transferred.
- R7: A write to the same register that is being transferred in that cycle copies the older value, and the register stays stale with the new value pending.
- R8: A `force_upd` pulse, or an accepted write to index 1 with data bit 31 set, makes all eight stale bits 1 on the next cycle. The registers are then transferred in index order 0 to 7.
- R9: While `cp_ready` is 0 and no write or force occurs, `cp_valid`, `cp_idx` and `cp_data` hold their values.
- R10: With `cp_ready` held at 1 and no new writes, N stale registers drain in exactly N consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Bus write request |
| wr_ready | output | 1 | Write accept, tied high |
| wr_idx | input | 3 | Register index for the write |
| wr_data | input | 32 | Write data |
| force_upd | input | 1 | Pulse: mark all registers stale |
| cp_valid | output | 1 | A transfer is offered |
| cp_ready | input | 1 | Slow domain takes the offered transfer |
| cp_idx | output | 3 | Index of the offered register |
| cp_data | output | 32 | Pending value of the offered register |
| rd_idx | input | 3 | Slow copy read select |
| rd_data | output | 32 | Slow copy selected by `rd_idx` |
| stale_map | output | 8 | Stale bit per register |
| stat_word | output | 32 | Status word with stale bits at 23:16 |

## Verification
A wrong stale bit shows up on the cycle after the write or transfer that caused it. It appears on `stale_map` and `stat_word`, and it also moves the `cp_idx` offer. A wrong pending value stays hidden until its register is offered, and then it appears on `cp_data`. A wrong slow copy appears on `rd_data` one cycle after the handshake. The bench therefore compares every output against a behavioural model on every clock, so a divergence is reported in the cycle it first becomes visible.

// File: rtl/shadow_seq_pkg.sv
package shadow_seq_pkg;
  localparam int unsigned REG_COUNT    = 8;
  localparam int unsigned WORD_W       = 32;
  localparam int unsigned STAT_LSB     = 16;
  localparam int unsigned FORCE_REG    = 1;
  localparam int unsigned FORCE_BITPOS = 31;
endpackage

// File: rtl/shd_pick.sv
module shd_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/shd_stale.sv
module shd_stale #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         set_all,
  output logic [N-1:0] stale
);
  logic [N-1:0] stale_nx;

  always_comb begin
    stale_nx = (stale & ~clr_vec) | set_vec;
    if (set_all) stale_nx = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stale <= '0;
    else        stale <= stale_nx;
  end
endmodule

// File: rtl/shd_bank.sv
module shd_bank #(
  parameter int unsigned N  = 8,
  parameter int unsigned DW = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         wr_sel,
  input  logic [DW-1:0]         wr_val,
  input  logic                  xfer_en,
  input  logic [IW-1:0]         xfer_sel,
  input  logic [IW-1:0]         rd_sel,
  output logic [DW-1:0]         xfer_val,
  output logic [DW-1:0]         rd_val
);
  logic [N-1:0][DW-1:0] pend_q;
  logic [N-1:0][DW-1:0] slow_q;

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[g] <= '0;
        slow_q[g] <= '0;
      end else begin
        if (wr_en && wr_sel == IW'(g))     pend_q[g] <= wr_val;
        if (xfer_en && xfer_sel == IW'(g)) slow_q[g] <= pend_q[g];
      end
    end
  end

  always_comb begin
    xfer_val = '0;
    rd_val   = '0;
    for (int i = 0; i < N; i++) begin
      if (xfer_sel == IW'(i)) xfer_val = pend_q[i];
      if (rd_sel == IW'(i))   rd_val   = slow_q[i];
    end
  end
endmodule

// File: rtl/shadow_upd_seq.sv
module shadow_upd_seq
  import shadow_seq_pkg::*;
#(
  parameter int unsigned NREG      = REG_COUNT,
  parameter int unsigned DW        = WORD_W,
  parameter int unsigned SW        = 32,
  parameter int unsigned STALE_LSB = STAT_LSB,
  parameter int unsigned FORCE_IDX = FORCE_REG,
  parameter int unsigned FORCE_BIT = FORCE_BITPOS,
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            force_upd,
  output logic            cp_valid,
  input  logic            cp_ready,
  output logic [IW-1:0]   cp_idx,
  output logic [DW-1:0]   cp_data,
  input  logic [IW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic [NREG-1:0] stale_map,
  output logic [SW-1:0]   stat_word
);
  logic            wr_fire;
  logic            xfer;
  logic            wr_forces;
  logic [NREG-1:0] set_vec;
  logic [NREG-1:0] clr_vec;

  assign wr_ready  = 1'b1;
  assign wr_fire   = wr_valid && wr_ready;
  assign xfer      = cp_valid && cp_ready;
  assign wr_forces = wr_fire && (wr_idx == IW'(FORCE_IDX)) && wr_data[FORCE_BIT];
  assign set_vec   = wr_fire ? (NREG'(1) << wr_idx) : '0;
  assign clr_vec   = xfer ? (NREG'(1) << cp_idx) : '0;

  shd_pick #(.N(NREG)) u_pick (
    .req (stale_map),
    .any (cp_valid),
    .idx (cp_idx)
  );

  shd_stale #(.N(NREG)) u_stale (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .set_all (force_upd || wr_forces),
    .stale   (stale_map)
  );

  shd_bank #(.N(NREG), .DW(DW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_sel   (wr_idx),
    .wr_val   (wr_data),
    .xfer_en  (xfer),
    .xfer_sel (cp_idx),
    .rd_sel   (rd_idx),
    .xfer_val (cp_data),
    .rd_val   (rd_data)
  );

  always_comb begin
    stat_word = '0;
    stat_word[STALE_LSB +: NREG] = stale_map;
  end
endmodule

// File: rtl/shadow_upd_seq_chk.sv
module shadow_upd_seq_chk #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 32,
  parameter int unsigned SW   = 32,
  localparam int unsigned IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [IW-1:0]   wr_idx,
  input logic            wr_force,
  input logic            force_upd,
  input logic            cp_valid,
  input logic            cp_ready,
  input logic [IW-1:0]   cp_idx,
  input logic [DW-1:0]   cp_data,
  input logic [NREG-1:0] stale_map,
  input logic [SW-1:0]   stat_word
);
  logic [NREG-1:0] below;
  assign below = (NREG'(1) << cp_idx) - NREG'(1);

  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n) wr_ready);

  p_wr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> stale_map[$past(wr_idx)]);

  p_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid == (stat_word != '0));

  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cp_valid |-> (stale_map[cp_idx] && ((stale_map & below) == '0)));

  p_copy_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && cp_ready && !(wr_valid && wr_idx == cp_idx) && !force_upd && !wr_force)
    |=> !stale_map[$past(cp_idx)]);

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && cp_ready && wr_valid && wr_idx == cp_idx) |=> stale_map[$past(cp_idx)]);

  p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_upd || wr_force) |=> (&stale_map));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !cp_ready && !wr_valid && !force_upd)
    |=> (cp_valid && $stable(cp_idx) && $stable(cp_data)));
endmodule

bind shadow_upd_seq shadow_upd_seq_chk #(.NREG(NREG), .DW(DW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_idx    (wr_idx),
  .wr_force  (wr_valid && wr_ready && (wr_idx == IW'(FORCE_IDX)) && wr_data[FORCE_BIT]),
  .force_upd (force_upd),
  .cp_valid  (cp_valid),
  .cp_ready  (cp_ready),
  .cp_idx    (cp_idx),
  .cp_data   (cp_data),
  .stale_map (stale_map),
  .stat_word (stat_word)
);

// File: tb/shadow_upd_seq_tb.sv
module shadow_upd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        force_upd = 1'b0;
  logic        cp_valid;
  logic        cp_ready = 1'b0;
  logic [2:0]  cp_idx;
  logic [31:0] cp_data;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic [7:0]  stale_map;
  logic [31:0] stat_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  logic [31:0] mpend [8];
  logic [31:0] mslow [8];
  logic [7:0]  mstale = '0;

  always #10 clk = ~clk;

  shadow_upd_seq u_dut (.*);

  function automatic int lowest(input logic [7:0] s);
    for (int i = 0; i < 8; i++) if (s[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model, compared against pre-edge outputs, then advanced
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      mstale = '0;
      for (int i = 0; i < 8; i++) begin mpend[i] = '0; mslow[i] = '0; end
      model_on = 1'b1;
    end else begin
      logic [7:0] nx;
      int lo;
      if (model_on) begin
        chk("R3 per-cycle stat_word", stat_word, {8'h00, mstale, 16'h0000});
        chk("R4 per-cycle cp_valid", {31'b0, cp_valid}, {31'b0, mstale != 0});
        if (mstale != 0) begin
          chk("R4 per-cycle cp_idx", {29'b0, cp_idx}, lowest(mstale));
          chk("R4 per-cycle cp_data", cp_data, mpend[lowest(mstale)]);
        end
        chk("R5 per-cycle rd_data", rd_data, mslow[rd_idx]);
      end
      nx = mstale;
      lo = lowest(mstale);
      if (cp_ready && mstale != 0) begin
        mslow[lo] = mpend[lo];
        nx[lo] = 1'b0;
      end
      if (wr_valid) begin
        mpend[wr_idx] = wr_data;
        nx[wr_idx] = 1'b1;
        if (wr_idx == 3'd1 && wr_data[31]) nx = '1;
      end
      if (force_upd) nx = '1;
      mstale = nx;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] i, input logic [31:0] d);
    wr_valid = 1'b1; wr_idx = i; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 stale_map", {24'b0, stale_map}, 32'h0);
    chk("R1 stat_word", stat_word, 32'h0);
    chk("R1 cp_valid", {31'b0, cp_valid}, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i); #1;
      chk("R1 slow copy", rd_data, 32'h0);
    end
    chk("R2 wr_ready", {31'b0, wr_ready}, 32'h1);

    // R2/R3/R4: writes with sink stalled
    wr(3'd7, 32'hA0A0_0007);
    chk("R2 seconds stale", {24'b0, stale_map}, 32'h80);
    chk("R3 seconds at bit 23", stat_word, 32'h0080_0000);
    wr(3'd3, 32'hB0B0_0003);
    wr(3'd0, 32'hC0C0_0000);
    chk("R3 stat_word map", stat_word, 32'h0089_0000);
    chk("R4 lowest first", {29'b0, cp_idx}, 32'd0);
    chk("R4 cp_data", cp_data, 32'hC0C0_0000);

    // R6 rewrite while pending
    wr(3'd3, 32'hD0D0_0003);
    chk("R6 still stale", {31'b0, stale_map[3]}, 32'h1);
    // R9 hold while stalled
    repeat (3) tick();
    chk("R9 hold idx", {29'b0, cp_idx}, 32'd0);
    chk("R9 hold data", cp_data, 32'hC0C0_0000);

    // R5 one transfer
    cp_ready = 1'b1; tick(); cp_ready = 1'b0;
    rd_idx = 3'd0; #1;
    chk("R5 slow copy 0", rd_data, 32'hC0C0_0000);
    chk("R5 stale cleared", {24'b0, stale_map}, 32'h88);
    chk("R6 newest offered", cp_data, 32'hD0D0_0003);

    // R7 same-cycle write and transfer of register 3
    cp_ready = 1'b1; wr(3'd3, 32'hE0E0_0003); cp_ready = 1'b0;
    rd_idx = 3'd3; #1;
    chk("R7 old value copied", rd_data, 32'hD0D0_0003);
    chk("R7 stays stale", {24'b0, stale_map}, 32'h88);
    chk("R7 new value pending", cp_data, 32'hE0E0_0003);

    // R10 drain two
    cp_ready = 1'b1; tick(); tick(); cp_ready = 1'b0;
    chk("R10 drained in 2", {24'b0, stale_map}, 32'h0);
    rd_idx = 3'd7; #1;
    chk("R10 seconds copied", rd_data, 32'hA0A0_0007);

    // R8 force pulse, then in-order recopy
    force_upd = 1'b1; tick(); force_upd = 1'b0;
    chk("R8 force pulse all stale", {24'b0, stale_map}, 32'hFF);
    cp_ready = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk("R8 recopy order", {29'b0, cp_idx}, k);
      tick();
    end
    cp_ready = 1'b0;
    chk("R10 drained in 8", {24'b0, stale_map}, 32'h0);

    // R8 force via persistent 1 bit 31
    wr(3'd1, 32'h8000_0001);
    chk("R8 force via write", {24'b0, stale_map}, 32'hFF);
    wr(3'd6, 32'h0000_0666);
    cp_ready = 1'b1;
    repeat (8) tick();
    cp_ready = 1'b0;
    rd_idx = 3'd1; #1;
    chk("R8 persistent 1 copied", rd_data, 32'h8000_0001);
    rd_idx = 3'd6; #1;
    chk("R8 alarm copied", rd_data, 32'h0000_0666);
    chk("R10 idle after drain", {31'b0, cp_valid}, 32'h0);
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule